// File: doc/BRIEF.md
# Interruption Entry Context Saver

This block performs the hardware half of a fast context switch when an interruption is taken. A single-cycle take strobe from the interruption prioritizer arrives with a group code. The block then latches the status word that the handler must later restore. For end-of-instruction traps that word is the value after the instruction completed; for every other group it is the value the instruction started with. In the same step it presents a freshly built status word and a privilege of zero for the core to load, and stops tracking the two-entry pending-address queue so the return addresses stay put.

When the status word that was in effect at the interruption had its queue-enable (Q) bit set, the block also captures the instruction word, the fault space and the fault offset into parameter registers. It then copies seven general registers into shadow copies through one read port, one register per cycle. While that copy runs the block reports busy and refuses new take strobes. A one-cycle done pulse marks the end of every save. When Q was clear, neither the parameter registers nor the shadows are touched, and the save completes in a single cycle.

Top module: `intr_ctx_save`

## Requirements
- R1: During reset all outputs are zero: busy, done, load strobe, new status word, privilege, saved status word, parameter registers, address queue copies, shadow registers and read address.
- R2: Group codes are 0 = high-priority machine check, 1 = asynchronous group, 2 = execution-fault group, 3 = end-of-instruction trap group. On an accepted take the saved status word becomes the post-execution word for code 3 and the pre-execution word for every other code. It is visible on the cycle after the take.
- R3: On the cycle after an accepted take the new status word carries the default width bit at bit 4 and the default endian bit at bit 25. Bit 11 (machine check) is 1 only for group code 0. All other bits, including Q at bit 3, are 0.
- R4: The privilege output is 0 on the cycle after an accepted take. Otherwise it repeats the current privilege input with one cycle of delay.
- R5: The load strobe is high for exactly the cycle after each accepted take.
- R6: The effective Q is bit 3 of the word chosen in R2. The instruction, space and offset parameter registers take their inputs on an accepted take only when the effective Q is 1, and keep their old values otherwise.
- R7: With effective Q = 1 the read address steps through registers 1, 8, 9, 16, 17, 24, 25 on the seven cycles after the take. The read data of each cycle is stored in shadow slot 0 to 6 in that order. With effective Q = 0 no shadow slot changes.
- R8: With effective Q = 1, busy is high for the seven copy cycles and done rises on the cycle busy falls. With effective Q = 0, busy stays low and done is high on the cycle after the take. Done is always a one-cycle pulse.
- R9: A take strobe that arrives while busy is high is ignored. The saved status word and the parameter registers are unchanged afterwards, and no load strobe follows.
- R10: The queue copies take the front and back address inputs at each clock edge where bit 3 of the post-execution word is 1, no take is accepted and busy is low. They hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Interruption take strobe |
| grp_i | input | 2 | Group code of the interruption |
| psw_pre_i | input | SW | Status word at start of the instruction |
| psw_post_i | input | SW | Status word after execution (live word) |
| dflt_w_i | input | 1 | Default width bit |
| dflt_e_i | input | 1 | Default endian bit |
| cur_priv_i | input | PW | Current privilege level |
| insn_i | input | IW | Instruction word of the interrupted instruction |
| spc_i | input | DW | Space value tied to the interruption |
| off_i | input | DW | Offset value tied to the interruption |
| iaq_front_i | input | QW | Front pending instruction address |
| iaq_back_i | input | QW | Back pending instruction address |
| gr_raddr_o | output | 5 | General register read address |
| gr_rdata_i | input | DW | General register read data, same cycle |
| busy_o | output | 1 | Shadow copy in progress |
| done_o | output | 1 | Save complete pulse |
| ctx_ld_o | output | 1 | Load strobe for new status word and privilege |
| psw_new_o | output | SW | New status word to load |
| priv_o | output | PW | Privilege to run at |
| ipsw_o | output | SW | Saved status word |
| iir_o | output | IW | Saved instruction word |
| isr_o | output | DW | Saved space |
| ior_o | output | DW | Saved offset |
| iiaq_front_o | output | QW | Frozen front address |
| iiaq_back_o | output | QW | Frozen back address |
| shadow_o | output | 7*DW | Shadow registers, slot k at bits k*DW upward |

## Verification
The assertions assume the register file answers a read in the same cycle. They also assume the take strobe is a clean, reset-synchronous level sampled on the clock. The bench drives every input on the falling edge, and its register-file model is a combinational function of the read address. Its sweep covers all four group codes with the effective Q both set and clear. The Q bit of the word that should not be chosen always holds the opposite value, so a wrong selection shows up in the parameter-register gating as well as in the saved word. Second take strobes are issued only during copy cycles, where they must be dropped.

// File: rtl/intr_ctx_save.sv
module intr_ctx_save #(
  parameter int DW    = 32,
  parameter int SW    = 32,
  parameter int IW    = 32,
  parameter int QW    = 34,
  parameter int PW    = 2,
  parameter int Q_POS = 3,
  parameter int W_POS = 4,
  parameter int M_POS = 11,
  parameter int E_POS = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic [1:0]      grp_i,
  input  logic [SW-1:0]   psw_pre_i,
  input  logic [SW-1:0]   psw_post_i,
  input  logic            dflt_w_i,
  input  logic            dflt_e_i,
  input  logic [PW-1:0]   cur_priv_i,
  input  logic [IW-1:0]   insn_i,
  input  logic [DW-1:0]   spc_i,
  input  logic [DW-1:0]   off_i,
  input  logic [QW-1:0]   iaq_front_i,
  input  logic [QW-1:0]   iaq_back_i,
  output logic [4:0]      gr_raddr_o,
  input  logic [DW-1:0]   gr_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            ctx_ld_o,
  output logic [SW-1:0]   psw_new_o,
  output logic [PW-1:0]   priv_o,
  output logic [SW-1:0]   ipsw_o,
  output logic [IW-1:0]   iir_o,
  output logic [DW-1:0]   isr_o,
  output logic [DW-1:0]   ior_o,
  output logic [QW-1:0]   iiaq_front_o,
  output logic [QW-1:0]   iiaq_back_o,
  output logic [7*DW-1:0] shadow_o
);
  localparam int NSHD = 7;
  localparam int CW   = $clog2(NSHD);
  localparam logic [1:0] GRP_HPMC = 2'd0;
  localparam logic [1:0] GRP_TRAP = 2'd3;

  logic            busy_q, done_q, ctx_ld_q;
  logic [CW-1:0]   idx_q;
  logic [SW-1:0]   ipsw_q, psw_new_q, new_w;
  logic [PW-1:0]   priv_q;
  logic [IW-1:0]   iir_q;
  logic [DW-1:0]   isr_q, ior_q;
  logic [QW-1:0]   iiaq_f_q, iiaq_b_q;
  logic [DW-1:0]   shd_q [NSHD];

  wire            accept = take_i & ~busy_q;
  wire [SW-1:0]   save_w = (grp_i == GRP_TRAP) ? psw_post_i : psw_pre_i;
  wire            save_q = save_w[Q_POS];
  wire            track  = psw_post_i[Q_POS] & ~accept & ~busy_q;

  // slot k holds register 8*((k+1)/2) + ((k+1)%2): 1,8,9,16,17,24,25
  function automatic logic [4:0] slot_reg(input logic [CW-1:0] k);
    logic [CW:0] n;
    n = {1'b0, k} + 1'b1;
    return 5'((n >> 1) << 3) | 5'(n[0]);
  endfunction

  always_comb begin
    new_w        = '0;
    new_w[W_POS] = dflt_w_i;
    new_w[E_POS] = dflt_e_i;
    new_w[M_POS] = (grp_i == GRP_HPMC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      ctx_ld_q  <= 1'b0;
      idx_q     <= '0;
      ipsw_q    <= '0;
      psw_new_q <= '0;
      priv_q    <= '0;
      iir_q     <= '0;
      isr_q     <= '0;
      ior_q     <= '0;
    end else begin
      ctx_ld_q <= accept;
      priv_q   <= accept ? '0 : cur_priv_i;
      done_q   <= 1'b0;
      if (accept) begin
        ipsw_q    <= save_w;
        psw_new_q <= new_w;
        if (save_q) begin
          iir_q  <= insn_i;
          isr_q  <= spc_i;
          ior_q  <= off_i;
          busy_q <= 1'b1;
          idx_q  <= '0;
        end else begin
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (idx_q == CW'(NSHD - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iiaq_f_q <= '0;
      iiaq_b_q <= '0;
    end else if (track) begin
      iiaq_f_q <= iaq_front_i;
      iiaq_b_q <= iaq_back_i;
    end
  end

  for (genvar k = 0; k < NSHD; k++) begin : g_shd
    always_ff @(posedge clk) begin
      if (!rst_n)
        shd_q[k] <= '0;
      else if (busy_q && idx_q == CW'(k))
        shd_q[k] <= gr_rdata_i;
    end
    assign shadow_o[k*DW +: DW] = shd_q[k];
  end

  assign gr_raddr_o   = busy_q ? slot_reg(idx_q) : 5'd0;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign ctx_ld_o     = ctx_ld_q;
  assign psw_new_o    = psw_new_q;
  assign priv_o       = priv_q;
  assign ipsw_o       = ipsw_q;
  assign iir_o        = iir_q;
  assign isr_o        = isr_q;
  assign ior_o        = ior_q;
  assign iiaq_front_o = iiaq_f_q;
  assign iiaq_back_o  = iiaq_b_q;

  // R9
  take_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && take_i |=> $stable(ipsw_q) && $stable(iir_q) && !ctx_ld_q);
  // R8
  done_after_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !ctx_ld_q |=> !done_q);
  // R4
  priv_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_ld_q |-> priv_q == '0);
  // R3
  new_q_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_ld_q |-> !psw_new_q[Q_POS]);
  // R6
  ipr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !save_q |=> $stable(iir_q) && $stable(isr_q) && $stable(ior_q) && !busy_q);
  // R7
  raddr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> gr_raddr_o inside {5'd1, 5'd8, 5'd9, 5'd16, 5'd17, 5'd24, 5'd25});
  // R10
  iaq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(iiaq_f_q) && $stable(iiaq_b_q));
endmodule

// File: tb/intr_ctx_save_test.sv
module intr_ctx_save_test;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        take_i = 0, dflt_w_i = 0, dflt_e_i = 0;
  logic [1:0]  grp_i = 0, cur_priv_i = 0;
  logic [31:0] psw_pre_i = 0, psw_post_i = 0, insn_i = 0, spc_i = 0, off_i = 0;
  logic [33:0] iaq_front_i = 0, iaq_back_i = 0;
  logic [4:0]  gr_raddr_o;
  logic [31:0] gr_rdata_i, seed = 0;
  logic        busy_o, done_o, ctx_ld_o;
  logic [31:0] psw_new_o, ipsw_o, iir_o, isr_o, ior_o;
  logic [1:0]  priv_o;
  logic [33:0] iiaq_front_o, iiaq_back_o;
  logic [223:0] shadow_o;

  assign gr_rdata_i = seed ^ (32'(gr_raddr_o) * 32'h0101_0101);

  intr_ctx_save uut (.*);

  int checks = 0, errors = 0;
  logic [4:0]  regs [7] = '{5'd1, 5'd8, 5'd9, 5'd16, 5'd17, 5'd24, 5'd25};
  logic [31:0] e_shd [7];
  logic [31:0] e_iir = 0, e_isr = 0, e_ior = 0;

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic chk_shadows(input string r);
    for (int k = 0; k < 7; k++) chk(r, 64'(shadow_o[k*32 +: 32]), 64'(e_shd[k]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 7; k++) e_shd[k] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy_o), 0);
    chk("R1 done", 64'(done_o), 0);
    chk("R1 ld", 64'(ctx_ld_o), 0);
    chk("R1 new", 64'(psw_new_o), 0);
    chk("R1 priv", 64'(priv_o), 0);
    chk("R1 ipsw", 64'(ipsw_o), 0);
    chk("R1 iir", 64'({iir_o, isr_o}), 0);
    chk("R1 ior", 64'(ior_o), 0);
    chk("R1 iaq", 64'({iiaq_front_o[31:0], iiaq_back_o[31:0]}), 0);
    chk("R1 raddr", 64'(gr_raddr_o), 0);
    chk_shadows("R1 shadow");
    rst_n = 1;

    // R10 queue tracking and freezing
    psw_post_i = 32'h8; iaq_front_i = 34'h1_0000_0100; iaq_back_i = 34'h1_0000_0104;
    @(negedge clk);
    chk("R10 track front", 64'(iiaq_front_o), 64'h1_0000_0100);
    chk("R10 track back", 64'(iiaq_back_o), 64'h1_0000_0104);
    psw_post_i = 32'h0; iaq_front_i = 34'h2_0000_0200; iaq_back_i = 34'h2_0000_0204;
    @(negedge clk);
    chk("R10 hold q0", 64'(iiaq_front_o), 64'h1_0000_0100);
    psw_post_i = 32'h8; psw_pre_i = 32'h0; grp_i = 2'd1; take_i = 1;
    iaq_front_i = 34'h3_0000_0300; iaq_back_i = 34'h3_0000_0304;
    @(negedge clk);
    take_i = 0;
    chk("R10 hold take", 64'(iiaq_back_o), 64'h1_0000_0104);
    @(negedge clk);
    chk("R10 resume", 64'(iiaq_front_o), 64'h3_0000_0300);

    // sweep groups, Q, patterns
    cur_priv_i = 2'd3;
    for (int pat = 0; pat < 2; pat++)
      for (int g = 0; g < 4; g++)
        for (int q = 0; q < 2; q++) begin
          logic [31:0] base, pre, post, e_ipsw, e_new;
          logic dw, de;
          base = 32'h3C5A_9600 + 32'(pat) * 32'h0001_1111 + 32'(g) * 32'h0707_0000 + 32'(q) * 32'h50;
          pre = base; post = ~base;
          if (g == 3) begin post[3] = q[0]; pre[3] = ~q[0]; end
          else begin pre[3] = q[0]; post[3] = ~q[0]; end
          dw = pat[0]; de = g[0] ^ q[0];
          psw_pre_i = pre; psw_post_i = post; dflt_w_i = dw; dflt_e_i = de;
          grp_i = 2'(g); insn_i = base ^ 32'hFFFF_0000; spc_i = base + 32'h10; off_i = base + 32'h20;
          seed = base * 3;
          take_i = 1;
          @(negedge clk);
          e_ipsw = (g == 3) ? post : pre;
          e_new = 0; e_new[4] = dw; e_new[25] = de; e_new[11] = (g == 0);
          if (q == 1) begin e_iir = insn_i; e_isr = spc_i; e_ior = off_i; end
          chk("R5 load strobe", 64'(ctx_ld_o), 1);
          chk("R3 new status", 64'(psw_new_o), 64'(e_new));
          chk("R4 priv zero", 64'(priv_o), 0);
          chk("R2 saved status", 64'(ipsw_o), 64'(e_ipsw));
          chk("R6 iir", 64'(iir_o), 64'(e_iir));
          chk("R6 isr", 64'(isr_o), 64'(e_isr));
          chk("R6 ior", 64'(ior_o), 64'(e_ior));
          chk("R8 busy", 64'(busy_o), 64'(q));
          chk("R8 done", 64'(done_o), 64'(q == 0));
          if (q == 1) begin
            chk("R7 raddr", 64'(gr_raddr_o), 64'(regs[0]));
            psw_pre_i = ~pre; psw_post_i = ~post; insn_i = ~insn_i;
            take_i = 1;
            @(negedge clk);
            take_i = 0;
            chk("R9 ipsw kept", 64'(ipsw_o), 64'(e_ipsw));
            chk("R9 iir kept", 64'(iir_o), 64'(e_iir));
            chk("R9 no strobe", 64'(ctx_ld_o), 0);
            chk("R4 priv follows", 64'(priv_o), 3);
            for (int k = 1; k < 7; k++) begin
              chk("R7 raddr", 64'(gr_raddr_o), 64'(regs[k]));
              chk("R8 busy held", 64'(busy_o), 1);
              @(negedge clk);
            end
            for (int k = 0; k < 7; k++) e_shd[k] = seed ^ (32'(regs[k]) * 32'h0101_0101);
            chk("R8 busy end", 64'(busy_o), 0);
            chk("R8 done end", 64'(done_o), 1);
            chk_shadows("R7 shadow");
            @(negedge clk);
            chk("R8 done pulse", 64'(done_o), 0);
          end else begin
            take_i = 0;
            @(negedge clk);
            chk("R8 done pulse", 64'(done_o), 0);
            chk("R5 strobe end", 64'(ctx_ld_o), 0);
            chk("R4 priv follows", 64'(priv_o), 3);
            chk_shadows("R7 shadow untouched");
          end
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule